// File: doc/BRIEF.md
# TDM Serial Channel Slot Mapper

This block sits on a framed serial time-division bus running at 2.048 Mbit/s. The bus carries a 125 µs frame of 32 channels, and each channel has eight bits. The block moves four per-line channels between the bus and parallel bytes. The four channels are two bearer channels (B1, B2), one control channel (C) and one signalling channel (D). They travel on two serial ports: a voice/data port and a control port. One clock of `clk` equals one bit time on the bus. A one-clock frame pulse marks the clock just before bit 7 of channel 0.

Three configuration inputs select where each channel lands. The first picks single-port or dual-port operation. The second picks the 80 or 160 kbit/s line rate, which decides whether B2 is carried. The third swaps C and D on the control port. Outside its own channels the block releases each port by dropping that port's output enable, so other devices can drive those channels. A global disable releases both ports at once.

The block also produces a frame pulse delayed by one channel time. A second identical device fed with this pulse owns the channels one slot later, and up to 16 devices can share one bus this way.

Top module: `tdm_slot_mapper`

## Requirements
- R1: When `frame_i` is high in cycle F, cycle F+1 carries position 0. Position p is channel p/8, bit 7-(p mod 8), and the position wraps after 255. A frame pulse at any other position restarts counting at position 0 in the next cycle and raises no error.
- R2: Each channel is sent most significant bit first: bit 7 in the first of its eight cycles and bit 0 in the last.
- R3: In dual-port mode (`cfg_single_i`=0), the voice/data port carries B1 in channel 0. It carries B2 in channel 16 only when `cfg_rate160_i`=1.
- R4: In dual-port mode, the control port carries D in channel 0 and C in channel 16 when `cfg_swap_cd_i`=0. When `cfg_swap_cd_i`=1 it carries C in channel 0 and D in channel 16.
- R5: In single-port mode (`cfg_single_i`=1), the voice/data port carries D in channel 0, C in channel 1 and B1 in channel 2, plus B2 in channel 3 when `cfg_rate160_i`=1. The control port is never driven, and `cfg_swap_cd_i` has no effect.
- R6: Each output enable is low in every channel the block does not own on that port. Both enables stay low from reset until the first frame pulse.
- R7: While `out_dis_i` is high, both output enables are low in that same cycle. Reception is unaffected.
- R8: A transmit byte is sampled in the cycle just before its channel's first bit. Changing the input later in the channel does not alter the bits sent.
- R9: Received bits of an owned channel are assembled MSB first. The `*_rx_o` outputs change only in the cycle after a frame pulse, and they then show the bytes completed in the frame just ended.
- R10: `frame_o` is `frame_i` delayed by exactly 8 clocks.
- R11: After reset, both enables are low, `frame_o` is low and all received bytes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one clock per bus bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Frame pulse, high in the clock before position 0 |
| cfg_single_i | input | 1 | 1 = single-port mode, 0 = dual-port mode |
| cfg_rate160_i | input | 1 | 1 = 160 kbit/s (B2 carried), 0 = 80 kbit/s |
| cfg_swap_cd_i | input | 1 | 1 = C in channel 0 and D in channel 16 on the control port |
| out_dis_i | input | 1 | Forces both output enables low |
| b1_tx_i | input | 8 | B1 byte to transmit |
| b2_tx_i | input | 8 | B2 byte to transmit |
| c_tx_i | input | 8 | C byte to transmit |
| d_tx_i | input | 8 | D byte to transmit |
| vd_rx_i | input | 1 | Voice/data port serial input |
| cd_rx_i | input | 1 | Control port serial input |
| vd_tx_o | output | 1 | Voice/data port serial output bit |
| vd_oe_o | output | 1 | Voice/data port drive enable (low = high impedance) |
| cd_tx_o | output | 1 | Control port serial output bit |
| cd_oe_o | output | 1 | Control port drive enable (low = high impedance) |
| b1_rx_o | output | 8 | Last complete received B1 byte |
| b2_rx_o | output | 8 | Last complete received B2 byte |
| c_rx_o | output | 8 | Last complete received C byte |
| d_rx_o | output | 8 | Last complete received D byte |
| frame_o | output | 1 | Frame pulse for the next device in the chain |

## Verification
Each result has a fixed latency, counted from the clock in which the bench drives the stimulus:
- Serial outputs for position p are registered and appear one clock after the cycle whose next position is p. The bench therefore checks enable and data one step after it drives the preceding position.
- The output disable acts in the same cycle.
- Received bytes appear one clock after the frame pulse. The bench compares them right after the frame boundary and again in mid-frame, which shows they held still.
- The chained pulse is compared against the bench's own 8-deep history of `frame_i`.

All inputs are driven and all outputs sampled 1 ns after the rising edge.

// File: rtl/tdm_map_pkg.sv
package tdm_map_pkg;

    localparam int NUM_CH = 4;
    localparam int IDX_B1 = 0;
    localparam int IDX_B2 = 1;
    localparam int IDX_C  = 2;
    localparam int IDX_D  = 3;

    typedef enum logic [2:0] {CH_NONE, CH_B1, CH_B2, CH_C, CH_D} chan_e;

    typedef struct packed {
        logic single;
        logic rate160;
        logic swap_cd;
    } map_cfg_t;

    // Which line channel a port carries in a given bus slot.
    function automatic chan_e slot_owner(input logic on_cd, input map_cfg_t cfg,
                                         input int unsigned slot, input int unsigned half);
        chan_e c;
        c = CH_NONE;
        if (cfg.single) begin
            if (!on_cd) begin
                case (slot)
                    0:       c = CH_D;
                    1:       c = CH_C;
                    2:       c = CH_B1;
                    3:       c = cfg.rate160 ? CH_B2 : CH_NONE;
                    default: c = CH_NONE;
                endcase
            end
        end else if (!on_cd) begin
            if (slot == 0)                       c = CH_B1;
            else if (slot == half && cfg.rate160) c = CH_B2;
        end else begin
            if (slot == 0)         c = cfg.swap_cd ? CH_C : CH_D;
            else if (slot == half) c = cfg.swap_cd ? CH_D : CH_C;
        end
        return c;
    endfunction

    function automatic int unsigned chan_index(input chan_e c);
        int unsigned i;
        case (c)
            CH_B2:   i = IDX_B2;
            CH_C:    i = IDX_C;
            CH_D:    i = IDX_D;
            default: i = IDX_B1;
        endcase
        return i;
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
    parameter int SLOTS = 32,
    parameter int BITS  = 8,
    parameter int POS_W = $clog2(SLOTS * BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    output logic [POS_W-1:0] pos_q_o,
    output logic [POS_W-1:0] pos_d_o,
    output logic             locked_q_o,
    output logic             locked_d_o,
    output logic             frame_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOTS * BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             locked;
        logic [BITS-1:0]  chain;
    } tmr_s;

    tmr_s tmr_q, tmr_d;

    always_comb begin
        tmr_d       = tmr_q;
        tmr_d.chain = {tmr_q.chain[BITS-2:0], frame_i};
        if (frame_i) begin
            tmr_d.pos    = '0;
            tmr_d.locked = 1'b1;
        end else if (tmr_q.pos == LAST_POS) begin
            tmr_d.pos = '0;
        end else begin
            tmr_d.pos = tmr_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign pos_q_o    = tmr_q.pos;
    assign pos_d_o    = tmr_d.pos;
    assign locked_q_o = tmr_q.locked;
    assign locked_d_o = tmr_d.locked;
    assign frame_o    = tmr_q.chain[BITS-1];

    // R1: any frame pulse restarts the position in the following cycle
    p_resync_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> (pos_q_o == '0) && locked_q_o);

endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
    import tdm_map_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int BITS  = 8,
    parameter int POS_W = $clog2(SLOTS * BITS),
    parameter bit ON_CD = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  map_cfg_t                     cfg_i,
    input  logic [POS_W-1:0]             pos_next_i,
    input  logic                         locked_next_i,
    input  logic [NUM_CH-1:0][BITS-1:0]  data_i,
    output logic                         bit_o,
    output logic                         own_o
);
    localparam int BW   = $clog2(BITS);
    localparam int HALF = SLOTS / 2;

    typedef struct packed {
        logic [BITS-1:0] sh;
        logic            own;
    } txl_s;

    txl_s  txl_q, txl_d;
    chan_e who;
    int unsigned slot_n;

    always_comb begin
        txl_d  = txl_q;
        slot_n = 32'(pos_next_i[POS_W-1:BW]);
        who    = slot_owner(ON_CD, cfg_i, slot_n, HALF);
        txl_d.own = locked_next_i && (who != CH_NONE);
        if (txl_d.own && (pos_next_i[BW-1:0] == '0)) begin
            txl_d.sh = data_i[chan_index(who)];
        end else begin
            txl_d.sh = {txl_q.sh[BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txl_q <= '0;
        else        txl_q <= txl_d;
    end

    assign bit_o = txl_q.sh[BITS-1];
    assign own_o = txl_q.own;

endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture
    import tdm_map_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int BITS  = 8,
    parameter int POS_W = $clog2(SLOTS * BITS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  map_cfg_t                     cfg_i,
    input  logic [POS_W-1:0]             pos_i,
    input  logic                         locked_i,
    input  logic                         frame_i,
    input  logic [1:0]                   line_i,
    output logic [NUM_CH-1:0][BITS-1:0]  ch_o
);
    localparam int BW   = $clog2(BITS);
    localparam int HALF = SLOTS / 2;

    typedef struct packed {
        logic [1:0][BITS-1:0]        sh;
        logic [NUM_CH-1:0][BITS-1:0] hold;
        logic [NUM_CH-1:0][BITS-1:0] vis;
    } rxc_s;

    rxc_s  rxc_q, rxc_d;
    chan_e who;
    int unsigned slot_n;

    always_comb begin
        rxc_d  = rxc_q;
        who    = CH_NONE;
        slot_n = 32'(pos_i[POS_W-1:BW]);
        for (int p = 0; p < 2; p++) begin
            who = slot_owner(p == 1, cfg_i, slot_n, HALF);
            if (locked_i && (who != CH_NONE)) begin
                rxc_d.sh[p] = {rxc_q.sh[p][BITS-2:0], line_i[p]};
                if (&pos_i[BW-1:0]) begin
                    rxc_d.hold[chan_index(who)] = rxc_d.sh[p];
                end
            end
        end
        if (frame_i) rxc_d.vis = rxc_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rxc_q <= '0;
        else        rxc_q <= rxc_d;
    end

    assign ch_o = rxc_q.vis;

    // R9: visible bytes only move at a frame boundary
    p_rx_frame_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_i) |-> $stable(rxc_q.vis));

endmodule

// File: rtl/tdm_slot_mapper.sv
module tdm_slot_mapper
    import tdm_map_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int BITS  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_i,
    input  logic            cfg_single_i,
    input  logic            cfg_rate160_i,
    input  logic            cfg_swap_cd_i,
    input  logic            out_dis_i,
    input  logic [BITS-1:0] b1_tx_i,
    input  logic [BITS-1:0] b2_tx_i,
    input  logic [BITS-1:0] c_tx_i,
    input  logic [BITS-1:0] d_tx_i,
    input  logic            vd_rx_i,
    input  logic            cd_rx_i,
    output logic            vd_tx_o,
    output logic            vd_oe_o,
    output logic            cd_tx_o,
    output logic            cd_oe_o,
    output logic [BITS-1:0] b1_rx_o,
    output logic [BITS-1:0] b2_rx_o,
    output logic [BITS-1:0] c_rx_o,
    output logic [BITS-1:0] d_rx_o,
    output logic            frame_o
);
    localparam int POS_W = $clog2(SLOTS * BITS);
    localparam int BW    = $clog2(BITS);

    map_cfg_t                    cfg;
    logic [POS_W-1:0]            pos_q, pos_d;
    logic                        locked_q, locked_d;
    logic [NUM_CH-1:0][BITS-1:0] tx_bus;
    logic [NUM_CH-1:0][BITS-1:0] rx_bus;
    logic [1:0]                  tx_bit, tx_own;

    assign cfg = {cfg_single_i, cfg_rate160_i, cfg_swap_cd_i};

    assign tx_bus[IDX_B1] = b1_tx_i;
    assign tx_bus[IDX_B2] = b2_tx_i;
    assign tx_bus[IDX_C]  = c_tx_i;
    assign tx_bus[IDX_D]  = d_tx_i;

    tdm_frame_timer #(.SLOTS(SLOTS), .BITS(BITS), .POS_W(POS_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_i    (frame_i),
        .pos_q_o    (pos_q),
        .pos_d_o    (pos_d),
        .locked_q_o (locked_q),
        .locked_d_o (locked_d),
        .frame_o    (frame_o)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        tdm_tx_lane #(.SLOTS(SLOTS), .BITS(BITS), .POS_W(POS_W), .ON_CD(g == 1)) u_tx (
            .clk           (clk),
            .rst_n         (rst_n),
            .cfg_i         (cfg),
            .pos_next_i    (pos_d),
            .locked_next_i (locked_d),
            .data_i        (tx_bus),
            .bit_o         (tx_bit[g]),
            .own_o         (tx_own[g])
        );
    end

    tdm_rx_capture #(.SLOTS(SLOTS), .BITS(BITS), .POS_W(POS_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    (cfg),
        .pos_i    (pos_q),
        .locked_i (locked_q),
        .frame_i  (frame_i),
        .line_i   ({cd_rx_i, vd_rx_i}),
        .ch_o     (rx_bus)
    );

    assign vd_tx_o = tx_bit[0];
    assign cd_tx_o = tx_bit[1];
    assign vd_oe_o = tx_own[0] & ~out_dis_i;
    assign cd_oe_o = tx_own[1] & ~out_dis_i;

    assign b1_rx_o = rx_bus[IDX_B1];
    assign b2_rx_o = rx_bus[IDX_B2];
    assign c_rx_o  = rx_bus[IDX_C];
    assign d_rx_o  = rx_bus[IDX_D];

    // R6: nothing is driven before the first frame pulse
    p_quiet_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_q |-> (tx_own == 2'b00));

    // R6: a drive window always opens on a channel boundary
    p_window_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_own[0]) |-> (pos_q[BW-1:0] == '0));

    // R5: control port stays released in single-port mode
    p_cd_quiet_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_single_i && $past(cfg_single_i)) |-> !cd_oe_o);

endmodule

// File: tb/tdm_slot_mapper_bench.sv
`timescale 1ns/1ps
module tdm_slot_mapper_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_i = 1'b0;
    logic       cfg_single_i = 1'b0, cfg_rate160_i = 1'b0, cfg_swap_cd_i = 1'b0;
    logic       out_dis_i = 1'b0;
    logic [7:0] b1_tx_i = '0, b2_tx_i = '0, c_tx_i = '0, d_tx_i = '0;
    logic       vd_rx_i = 1'b0, cd_rx_i = 1'b0;
    logic       vd_tx_o, vd_oe_o, cd_tx_o, cd_oe_o, frame_o;
    logic [7:0] b1_rx_o, b2_rx_o, c_rx_o, d_rx_o;

    always #2 clk = ~clk;

    tdm_slot_mapper u_tdm_slot_mapper (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
        .cfg_single_i(cfg_single_i), .cfg_rate160_i(cfg_rate160_i), .cfg_swap_cd_i(cfg_swap_cd_i),
        .out_dis_i(out_dis_i),
        .b1_tx_i(b1_tx_i), .b2_tx_i(b2_tx_i), .c_tx_i(c_tx_i), .d_tx_i(d_tx_i),
        .vd_rx_i(vd_rx_i), .cd_rx_i(cd_rx_i),
        .vd_tx_o(vd_tx_o), .vd_oe_o(vd_oe_o), .cd_tx_o(cd_tx_o), .cd_oe_o(cd_oe_o),
        .b1_rx_o(b1_rx_o), .b2_rx_o(b2_rx_o), .c_rx_o(c_rx_o), .d_rx_o(d_rx_o),
        .frame_o(frame_o)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int pos = -1;
    int fno = 0;
    bit cur_single = 0, cur_r160 = 0, cur_swap = 0;
    bit nx_single = 0, nx_r160 = 0, nx_swap = 0;
    bit dis = 0, dis_prev = 0, r8_on = 0;
    int early_at = -1;
    logic [15:0] fr_hist = '0;
    logic [7:0] exp_tx [4];
    logic [7:0] acc [4];
    logic [7:0] prev [4];
    bit accv [4];
    bit prevv [4];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s pos=%0d actual=%0h expected=%0h", req, pos, act, exp);
        end
    endtask

    // Channel index 0=B1 1=B2 2=C 3=D, -1 when the slot is not owned.
    function automatic int owner(input int port, input int slot);
        if (cur_single) begin
            if (port == 1) return -1;
            if (slot == 0) return 3;
            if (slot == 1) return 2;
            if (slot == 2) return 0;
            if (slot == 3 && cur_r160) return 1;
            return -1;
        end
        if (port == 0) begin
            if (slot == 0) return 0;
            if (slot == 16 && cur_r160) return 1;
            return -1;
        end
        if (slot == 0)  return cur_swap ? 2 : 3;
        if (slot == 16) return cur_swap ? 3 : 2;
        return -1;
    endfunction

    function automatic logic [7:0] rxpat(input int port, input int slot, input int f);
        return 8'(slot * 37 + f * 11 + port * 101 + 90);
    endfunction

    task automatic check_all();
        for (int p = 0; p < 2; p++) begin
            int own;
            bit eoe, aoe, abit;
            string tag;
            own  = (pos >= 0) ? owner(p, pos / 8) : -1;
            eoe  = (own >= 0) && !dis;
            aoe  = (p == 0) ? vd_oe_o : cd_oe_o;
            abit = (p == 0) ? vd_tx_o : cd_tx_o;
            if (pos < 0 || own < 0) tag = "R6";
            else if (dis)           tag = "R7";
            else if (cur_single)    tag = "R5";
            else if (p == 0)        tag = "R3";
            else                    tag = "R4";
            chk(aoe == eoe, tag, 32'(aoe), 32'(eoe));
            if (eoe) begin
                logic eb;
                eb = exp_tx[own][7 - pos % 8];
                chk(abit == eb, (r8_on && own == 0) ? "R8" : "R2", 32'(abit), 32'(eb));
            end
        end
        chk(frame_o == fr_hist[7], "R10", 32'(frame_o), 32'(fr_hist[7]));
        if (pos == 0 || pos == 200) begin
            logic [7:0] got [4];
            got[0] = b1_rx_o; got[1] = b2_rx_o; got[2] = c_rx_o; got[3] = d_rx_o;
            for (int c = 0; c < 4; c++)
                if (prevv[c]) chk(got[c] == prev[c], dis_prev ? "R7" : "R9", 32'(got[c]), 32'(prev[c]));
        end
    endtask

    task automatic step(input bit fr);
        if (pos >= 0) begin
            for (int p = 0; p < 2; p++) begin
                logic [7:0] byt;
                int own, b;
                byt = rxpat(p, pos / 8, fno);
                own = owner(p, pos / 8);
                b   = 7 - pos % 8;
                if (p == 0) vd_rx_i = byt[b]; else cd_rx_i = byt[b];
                if (own >= 0 && b == 0) begin acc[own] = byt; accv[own] = 1; end
            end
        end else begin
            vd_rx_i = 1'b0; cd_rx_i = 1'b0;
        end
        if (r8_on && pos == 3) b1_tx_i = ~exp_tx[0];
        if (fr) begin
            fno++;
            for (int c = 0; c < 4; c++) begin
                exp_tx[c] = 8'(fno * 29 + c * 71 + 19);
                prev[c] = acc[c]; prevv[c] = accv[c]; accv[c] = 0;
            end
            dis_prev = dis;
            b1_tx_i = exp_tx[0]; b2_tx_i = exp_tx[1]; c_tx_i = exp_tx[2]; d_tx_i = exp_tx[3];
            cur_single = nx_single; cur_r160 = nx_r160; cur_swap = nx_swap;
            cfg_single_i = cur_single; cfg_rate160_i = cur_r160; cfg_swap_cd_i = cur_swap;
        end
        frame_i   = fr;
        out_dis_i = dis;
        @(posedge clk); #1;
        fr_hist = {fr_hist[14:0], fr};
        if (fr) pos = 0;
        else if (pos >= 0) pos = (pos + 1) % 256;
        check_all();
    endtask

    task automatic run_frames(input int n);
        int cnt = 0;
        while (cnt < n) begin
            bit fr, early;
            early = (early_at >= 0 && pos == early_at);
            fr = (pos < 0) || (pos == 255) || early;
            step(fr);
            if (fr) cnt++;
            if (early) begin
                early_at = -1;
                // R1: early pulse restarts at channel 0, bit 7 of B1
                chk(vd_oe_o == 1'b1, "R1", 32'(vd_oe_o), 32'd1);
                chk(vd_tx_o == exp_tx[0][7], "R1", 32'(vd_tx_o), 32'(exp_tx[0][7]));
            end
        end
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin
            exp_tx[c] = '0; acc[c] = '0; prev[c] = '0; accv[c] = 0; prevv[c] = 0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11: reset state
        chk(vd_oe_o == 0 && cd_oe_o == 0, "R11", {30'd0, vd_oe_o, cd_oe_o}, 32'd0);
        chk(frame_o == 0, "R11", 32'(frame_o), 32'd0);
        chk({b1_rx_o, b2_rx_o, c_rx_o, d_rx_o} == 32'd0, "R11",
            {b1_rx_o, b2_rx_o, c_rx_o, d_rx_o}, 32'd0);
        // R6: no drive before the first frame pulse
        repeat (20) step(1'b0);
        // Sweep every mode combination (R3, R4, R5, R2, R9, R10)
        for (int k = 0; k < 8; k++) begin
            nx_single = k[2]; nx_r160 = k[1]; nx_swap = k[0];
            run_frames(3);
        end
        nx_single = 0; nx_r160 = 1; nx_swap = 0;
        run_frames(1);
        // R8: mid-channel change of the B1 input
        r8_on = 1; run_frames(1); r8_on = 0;
        // R1: early frame pulse
        early_at = 100; run_frames(2);
        // R7: global disable for a whole frame, reception continues
        dis = 1; run_frames(1); dis = 0;
        run_frames(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule